// File: doc/BRIEF.md
# Pipelined Burst Synchronous Static Memory

This block is a small single-port synchronous memory built from 36-bit words. Each word is four byte lanes, and each lane holds 8 data bits plus a parity bit. The address and all control inputs are captured on the rising clock edge. Read data passes through two register stages before it reaches the output. An access starts when one of two active-low start strobes is seen. One strobe is meant for a processor and the other for a cache controller. The strobe loads the external address into a burst unit. A 2-bit counter in that unit then steps through the other three words of an aligned group of four each time the advance input is low.

Writes finish on the edge that samples them. They can cover the whole word or only the byte lanes that are selected. The counter steps through the group in either wrapping-increment order or XOR order, and an order input chooses between them. Three chip selects with mixed polarity gate every start. An output enable with no clock path blanks the read port. A sleep input freezes the block and keeps its contents.

Top module: `pburst_sram`

## Requirements
- R1: A word is 36 bits wide and is split into four lanes. Lane i occupies bits 9*i+8 down to 9*i, and write masking works per lane.
- R2: A start can come from `strobe_cpu_n` low while `sel0_n` is low, or from `strobe_cache_n` low. Either start loads `addr` as the burst base with a count of zero. When both are present the processor start wins. A processor start is always a read, whatever the write inputs are.
- R3: A start selects the block only if `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A start without selection ends the burst, and the read port stops driving after the second edge. `strobe_cpu_n` has no effect while `sel0_n` is high.
- R4: If a read is sampled at clock edge k, its word is on `rdata` with `rdata_drive`=1 after edge k+1.
- R5: A cycle with no start that falls inside an active burst accesses the next burst word when `advance_n`=0. When `advance_n`=1 it accesses the same word again.
- R6: When `burst_linear`=1, the low two address bits of each beat are (base + count) mod 4.
- R7: When `burst_linear`=0, the low two address bits of each beat are base XOR count. The upper bits always come from the base.
- R8: A beat uses the value `burst_linear` had on the edge before it.
- R9: `write_all_n`=0 writes all four lanes with `wdata` on the sampling edge. This happens on a cache start or on a burst continuation. A read of that word on the next cycle returns the new value.
- R10: With `write_all_n`=1 and `lane_wr_n`=0, only the lanes whose `lane_sel_n` bit is 0 are written, and the other lanes keep their contents. With no lane chosen, the access is a read.
- R11: While `out_en_n`=1, `rdata_drive` is 0 and `rdata` is 0 at once, without waiting for a clock edge.
- R12: While `sleep`=1, nothing is written, no read is started, the burst state holds and `rdata_drive` is 0. Stored words survive the sleep.
- R13: After reset no burst is active, the read port is not driving, and the order register holds the XOR order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address loaded on a start |
| strobe_cpu_n | input | 1 | Processor start strobe, active low |
| strobe_cache_n | input | 1 | Cache-controller start strobe, active low |
| advance_n | input | 1 | Step the burst counter, active low |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| burst_linear | input | 1 | 1 selects wrapping-increment order, 0 selects XOR order |
| write_all_n | input | 1 | Write every lane, active low |
| lane_wr_n | input | 1 | Enable per-lane writes, active low |
| lane_sel_n | input | 4 | Per-lane write select, active low, bit i is lane i |
| out_en_n | input | 1 | Output enable with no clock path, active low |
| sleep | input | 1 | Low-power hold, active high |
| wdata | input | 36 | Write data |
| rdata | output | 36 | Read data, zero while not driven |
| rdata_drive | output | 1 | High while the read port drives `rdata` |

## Verification
Some properties are checked on every cycle. The output enable and sleep must always blank the port. Sleep must freeze the burst state. A selected start must clear the count. A held advance must keep the count. An unselected start must turn the port off two edges later. A selected processor start must lead to driven data two edges later. Other behaviour can only be shown by the bench scenarios, because a property cannot express it. That covers the value of each word, the beat order in both modes, the one-edge delay on a mode change, merging of partial writes, strobes that must be ignored, and retention of contents across sleep. The bench uses a reference model of the address sequence and of the memory.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e          kind;
        logic [LANES-1:0]   lanes;
    } access_t;

    // low two address bits of a beat within its aligned group of four
    function automatic logic [1:0] beat_offset(input logic linear,
                                               input logic [1:0] base,
                                               input logic [1:0] count);
        return linear ? 2'(base + count) : (base ^ count);
    endfunction

endpackage

// File: rtl/pbs_burst_ctl.sv
module pbs_burst_ctl
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              strobe_cpu_n,
    input  logic              strobe_cache_n,
    input  logic              advance_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              write_all_n,
    input  logic              lane_wr_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic              burst_linear,
    input  logic              sleep,
    output access_t           acc,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              burst_active,
    output logic [1:0]        burst_count
);

    logic              chip_sel;
    logic              cpu_start;
    logic              any_start;
    logic [LANES-1:0]  wr_lanes;
    logic [1:0]        cnt_nx;
    logic              active_q;
    logic              linear_q;
    logic [1:0]        cnt_q;
    logic [ADDR_W-1:0] base_q;

    always_comb begin
        chip_sel  = !sel0_n && sel1 && !sel2_n;
        cpu_start = !strobe_cpu_n && !sel0_n;
        any_start = cpu_start || !strobe_cache_n;
        wr_lanes  = !write_all_n ? {LANES{1'b1}} :
                    (!lane_wr_n ? ~lane_sel_n : {LANES{1'b0}});
        cnt_nx    = cnt_q + {1'b0, !advance_n};

        acc.kind  = ACC_NONE;
        acc.lanes = '0;
        acc_addr  = base_q;
        if (!sleep) begin
            if (any_start) begin
                if (chip_sel) begin
                    acc_addr = addr;
                    if (!cpu_start && (|wr_lanes)) begin
                        acc.kind  = ACC_WRITE;
                        acc.lanes = wr_lanes;
                    end else begin
                        acc.kind = ACC_READ;
                    end
                end
            end else if (active_q) begin
                acc_addr = {base_q[ADDR_W-1:2],
                            beat_offset(linear_q, base_q[1:0], cnt_nx)};
                if (|wr_lanes) begin
                    acc.kind  = ACC_WRITE;
                    acc.lanes = wr_lanes;
                end else begin
                    acc.kind = ACC_READ;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            linear_q <= 1'b0;
            cnt_q    <= 2'd0;
            base_q   <= '0;
        end else begin
            linear_q <= burst_linear;
            if (!sleep) begin
                if (any_start) begin
                    active_q <= chip_sel;
                    if (chip_sel) begin
                        base_q <= addr;
                        cnt_q  <= 2'd0;
                    end
                end else if (active_q) begin
                    cnt_q <= cnt_nx;
                end
            end
        end
    end

    assign burst_active = active_q;
    assign burst_count  = cnt_q;

endmodule

// File: rtl/pbs_in_stage.sv
module pbs_in_stage
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              rd_pend,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              out_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend   <= 1'b0;
            rd_addr   <= '0;
            out_valid <= 1'b0;
        end else begin
            rd_pend   <= (acc.kind == ACC_READ);
            rd_addr   <= acc_addr;
            out_valid <= rd_pend;
        end
    end

endmodule

// File: rtl/pbs_lane_mem.sv
module pbs_lane_mem
    import pbs_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [LANES-1:0]  wr_lanes,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (wr_lanes[g]) begin
                store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
            if (rd_en) begin
                q <= store[rd_addr];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
    import pbs_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] addr,
    input  logic                     strobe_cpu_n,
    input  logic                     strobe_cache_n,
    input  logic                     advance_n,
    input  logic                     sel0_n,
    input  logic                     sel1,
    input  logic                     sel2_n,
    input  logic                     burst_linear,
    input  logic                     write_all_n,
    input  logic                     lane_wr_n,
    input  logic [3:0]               lane_sel_n,
    input  logic                     out_en_n,
    input  logic                     sleep,
    input  logic [35:0]              wdata,
    output logic [35:0]              rdata,
    output logic                     rdata_drive
);

    localparam int ADDR_W = $clog2(DEPTH);

    access_t           acc;
    logic [ADDR_W-1:0] acc_addr;
    logic              burst_active;
    logic [1:0]        burst_count;
    logic              rd_pend;
    logic [ADDR_W-1:0] rd_addr;
    logic              out_valid;
    logic [WORD_W-1:0] mem_q;

    pbs_burst_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk            (clk),
        .rst            (rst),
        .addr           (addr),
        .strobe_cpu_n   (strobe_cpu_n),
        .strobe_cache_n (strobe_cache_n),
        .advance_n      (advance_n),
        .sel0_n         (sel0_n),
        .sel1           (sel1),
        .sel2_n         (sel2_n),
        .write_all_n    (write_all_n),
        .lane_wr_n      (lane_wr_n),
        .lane_sel_n     (lane_sel_n),
        .burst_linear   (burst_linear),
        .sleep          (sleep),
        .acc            (acc),
        .acc_addr       (acc_addr),
        .burst_active   (burst_active),
        .burst_count    (burst_count)
    );

    pbs_in_stage #(.ADDR_W(ADDR_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .acc_addr  (acc_addr),
        .rd_pend   (rd_pend),
        .rd_addr   (rd_addr),
        .out_valid (out_valid)
    );

    pbs_lane_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
        .clk      (clk),
        .wr_lanes (acc.lanes),
        .wr_addr  (acc_addr),
        .wr_data  (wdata),
        .rd_en    (rd_pend),
        .rd_addr  (rd_addr),
        .rd_data  (mem_q)
    );

    assign rdata_drive = out_valid && !out_en_n && !sleep;
    assign rdata       = rdata_drive ? mem_q : '0;

endmodule

// File: rtl/pbs_chk.sv
module pbs_chk (
    input logic       clk,
    input logic       rst,
    input logic       strobe_cpu_n,
    input logic       strobe_cache_n,
    input logic       advance_n,
    input logic       sel0_n,
    input logic       sel1,
    input logic       sel2_n,
    input logic       out_en_n,
    input logic       sleep,
    input logic       rdata_drive,
    input logic       burst_active,
    input logic [1:0] burst_count
);

    logic picked;
    logic cpu_go;
    logic go;

    assign picked = !sel0_n && sel1 && !sel2_n;
    assign cpu_go = !strobe_cpu_n && !sel0_n;
    assign go     = cpu_go || !strobe_cache_n;

    // R11
    oe_blank_chk: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_drive);

    // R12
    sleep_blank_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !rdata_drive);

    // R12
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |=> ($stable(burst_count) && $stable(burst_active)));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (go && picked && !sleep) |=> (burst_active && burst_count == 2'd0));

    // R5
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_active && !go && advance_n && !sleep) |=> $stable(burst_count));

    // R3
    deselect_off_chk: assert property (@(posedge clk) disable iff (rst)
        (go && !picked && !sleep) |=> ##1 !rdata_drive);

    // R4
    read_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_go && picked && !sleep) |=> ##1 (rdata_drive || out_en_n || sleep));

endmodule

bind pburst_sram pbs_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .strobe_cpu_n   (strobe_cpu_n),
    .strobe_cache_n (strobe_cache_n),
    .advance_n      (advance_n),
    .sel0_n         (sel0_n),
    .sel1           (sel1),
    .sel2_n         (sel2_n),
    .out_en_n       (out_en_n),
    .sleep          (sleep),
    .rdata_drive    (rdata_drive),
    .burst_active   (burst_active),
    .burst_count    (burst_count)
);

// File: tb/sim_pburst_sram.sv
module sim_pburst_sram;

    localparam int DEPTH = 256;
    localparam int AW    = 8;
    localparam int W     = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          strobe_cpu_n = 1'b1, strobe_cache_n = 1'b1, advance_n = 1'b1;
    logic          sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
    logic          burst_linear = 1'b0, write_all_n = 1'b1, lane_wr_n = 1'b1;
    logic [3:0]    lane_sel_n = 4'hF;
    logic          out_en_n = 1'b0, sleep = 1'b0;
    logic [W-1:0]  wdata = '0;
    logic [W-1:0]  rdata;
    logic          rdata_drive;

    always #4 clk = ~clk;

    pburst_sram #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .addr(addr),
        .strobe_cpu_n(strobe_cpu_n), .strobe_cache_n(strobe_cache_n),
        .advance_n(advance_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .burst_linear(burst_linear), .write_all_n(write_all_n),
        .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n), .out_en_n(out_en_n),
        .sleep(sleep), .wdata(wdata), .rdata(rdata), .rdata_drive(rdata_drive)
    );

    typedef struct {
        int           tag;
        logic         drv;
        logic [W-1:0] data;
        string        req;
    } exp_t;

    exp_t         sb[$];
    int           cyc = 0;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;
    string        cur_req = "R13";

    // reference state
    logic [W-1:0]  mm [DEPTH];
    logic          m_act = 1'b0;
    logic          m_lin = 1'b0;
    logic [1:0]    m_cnt = 2'd0;
    logic [AW-1:0] m_base = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pat(int a);
        return {9'(a * 3 + 1), 9'(a ^ 9'h155), 9'(a + 9'h0A7), 9'(~a)};
    endfunction

    // driver: one clock of stimulus, model update, expected item into scoreboard
    task automatic tick();
        exp_t          e;
        logic          sel, ps, st, rd, wr;
        logic [3:0]    lanes;
        logic [AW-1:0] a;
        sel   = !sel0_n && sel1 && !sel2_n;
        ps    = !strobe_cpu_n && !sel0_n;
        st    = ps || !strobe_cache_n;
        lanes = !write_all_n ? 4'hF : (!lane_wr_n ? ~lane_sel_n : 4'h0);
        rd = 1'b0; wr = 1'b0; a = m_base;
        if (!sleep) begin
            if (st) begin
                if (sel) begin
                    a = addr; m_base = addr; m_cnt = 2'd0; m_act = 1'b1;
                    if (!ps && lanes != 4'h0) wr = 1'b1; else rd = 1'b1;
                end else begin
                    m_act = 1'b0;
                end
            end else if (m_act) begin
                if (!advance_n) m_cnt = m_cnt + 2'd1;
                a = {m_base[AW-1:2], m_lin ? 2'(m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
                if (lanes != 4'h0) wr = 1'b1; else rd = 1'b1;
            end
        end
        m_lin = burst_linear;
        if (wr) begin
            for (int i = 0; i < 4; i++) begin
                if (lanes[i]) mm[a][9*i +: 9] = wdata[9*i +: 9];
            end
        end
        e.tag  = cyc + 2;
        e.drv  = rd;
        e.data = rd ? mm[a] : '0;
        e.req  = cur_req;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].tag <= cyc) begin
                exp_t e;
                logic ed;
                e  = sb.pop_front();
                ed = e.drv && !out_en_n && !sleep;
                chk(e.req, {rdata_drive, rdata}, {ed, ed ? e.data : {W{1'b0}}});
            end
        end
    end

    task automatic cache_write(logic [AW-1:0] a, logic [W-1:0] d);
        strobe_cache_n = 1'b0; addr = a; write_all_n = 1'b0; wdata = d;
        tick();
        strobe_cache_n = 1'b1; write_all_n = 1'b1;
    endtask

    task automatic adv_write(logic [W-1:0] d);
        advance_n = 1'b0; write_all_n = 1'b0; wdata = d;
        tick();
        advance_n = 1'b1; write_all_n = 1'b1;
    endtask

    task automatic cpu_read(logic [AW-1:0] a);
        strobe_cpu_n = 1'b0; addr = a;
        tick();
        strobe_cpu_n = 1'b1;
    endtask

    task automatic adv_read();
        advance_n = 1'b0;
        tick();
        advance_n = 1'b1;
    endtask

    task automatic deselect();
        strobe_cache_n = 1'b0; sel1 = 1'b0;
        tick();
        strobe_cache_n = 1'b1; sel1 = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        // R13 reset state
        chk("R13", {rdata_drive, rdata}, '0);
        tick();
        chk("R13", {rdata_drive, rdata}, '0);

        // R9 fill every word with global-write bursts
        cur_req = "R9";
        for (int b = 0; b < DEPTH; b += 4) begin
            cache_write(AW'(b), pat(b));
            for (int k = 1; k < 4; k++) adv_write(pat(b + k));
        end
        cpu_read(8'd2);
        deselect();
        tick();

        // R6 wrapping-increment order
        cur_req = "R6";
        burst_linear = 1'b1; tick();
        cpu_read(8'd9);
        repeat (3) adv_read();

        // R7 XOR order
        cur_req = "R7";
        burst_linear = 1'b0; tick();
        cpu_read(8'd10);
        repeat (3) adv_read();

        // R5 held advance repeats the word
        cur_req = "R5";
        cpu_read(8'd4);
        tick();
        adv_read();
        tick();
        adv_read();

        // R8 order change applies one edge late
        cur_req = "R8";
        cpu_read(8'd13);
        burst_linear = 1'b1; adv_read();
        adv_read();
        adv_read();
        burst_linear = 1'b0; tick();

        // R10 R1 lane writes
        cur_req = "R10 R1";
        strobe_cache_n = 1'b0; addr = 8'd20; lane_wr_n = 1'b0;
        lane_sel_n = 4'b1010; wdata = '1;
        tick();
        strobe_cache_n = 1'b1; lane_wr_n = 1'b1; lane_sel_n = 4'hF;
        cpu_read(8'd20);
        // lane selects without lane write enable: plain read
        strobe_cache_n = 1'b0; addr = 8'd21; lane_sel_n = 4'h0; wdata = '0;
        tick();
        strobe_cache_n = 1'b1; lane_sel_n = 4'hF;
        cpu_read(8'd21);

        // R2 processor start ignores write inputs; wins over cache start
        cur_req = "R2";
        strobe_cpu_n = 1'b0; addr = 8'd22; write_all_n = 1'b0; wdata = '0;
        tick();
        strobe_cpu_n = 1'b1; write_all_n = 1'b1;
        cpu_read(8'd22);
        strobe_cpu_n = 1'b0; strobe_cache_n = 1'b0; addr = 8'd23;
        write_all_n = 1'b0; wdata = '0;
        tick();
        strobe_cpu_n = 1'b1; strobe_cache_n = 1'b1; write_all_n = 1'b1;
        cpu_read(8'd23);

        // R3 chip selects
        cur_req = "R3";
        cpu_read(8'd30);
        sel0_n = 1'b1; strobe_cpu_n = 1'b0; addr = 8'd40;
        adv_read();
        sel0_n = 1'b0; strobe_cpu_n = 1'b1;
        adv_read();
        strobe_cache_n = 1'b0; sel2_n = 1'b1;
        tick();
        strobe_cache_n = 1'b1; sel2_n = 1'b0;
        tick();
        tick();

        // R4 single read then deselect
        cur_req = "R4";
        cpu_read(8'd77);
        deselect();
        tick();

        // R11 output enable acts without a clock
        cur_req = "R11";
        cpu_read(8'd70);
        adv_read();
        out_en_n = 1'b1; #1;
        chk("R11", {rdata_drive, rdata}, '0);
        out_en_n = 1'b0; #1;
        chk("R11", {31'd0, rdata_drive}, {31'd0, 1'b1});
        adv_read();
        deselect();
        tick();

        // R12 sleep blocks writes and reads, keeps contents and burst
        cur_req = "R12";
        cpu_read(8'd50);
        sleep = 1'b1;
        cache_write(8'd60, '0);
        adv_write('0);
        tick();
        sleep = 1'b0;
        adv_read();
        cpu_read(8'd60);
        deselect();
        repeat (4) tick();

        finish_run();
    end

endmodule